// File: doc/BRIEF.md
# 16-bit ALU with Overflow Word

This is a purely combinational arithmetic and logic unit for a small word-addressed processor. It takes a destination operand B, a source operand A, a 5-bit basic opcode and the current value of the processor's 16-bit overflow word EX. It returns the 16-bit value to be written back into B, the candidate new EX value and a flag that says whether EX should be updated.

EX is a single 16-bit word that replaces a carry flag. What it holds depends on the operation. After an add or subtract it holds an overflow or borrow marker. After a multiply it holds the high half of the product. After a divide it holds the fractional bits of the quotient. After a shift it holds the bits that were shifted out. Dividing by zero is not an error: the result is simply zero. Operand fetch, writeback, memory access, conditional instructions and cycle counting belong to the surrounding processor.

All values below are hexadecimal. Signed means 16-bit two's complement.

Top module: `ovf_alu`

## Requirements
- R1: Opcode 01 (move) gives result = A and ex_we = 0.
- R2: Opcode 02 (add) gives result = (B+A) mod 2^16. EX is written with 0001 when B+A exceeds ffff and with 0000 otherwise.
- R3: Opcode 03 (subtract) gives result = (B−A) mod 2^16. EX is written with ffff when A > B (unsigned) and with 0000 otherwise.
- R4: Opcode 04 (unsigned multiply) and opcode 05 (signed multiply) put the low 16 bits of the 32-bit product in result and write its high 16 bits to EX.
- R5: With A ≠ 0, opcode 06 (unsigned divide) gives result = B/A and writes EX with the low 16 bits of (B·2^16)/A. Opcode 07 (signed divide) does the same with signed operands, and its quotients are truncated toward zero. For 8000/ffff the result is 8000 and EX is 0000.
- R6: With A = 0, opcodes 06, 07, 08 and 09 all give result 0000. Opcodes 06 and 07 write EX with 0000. Opcodes 08 and 09 do not write EX.
- R7: With A ≠ 0, opcode 08 gives the unsigned remainder B mod A. Opcode 09 gives the signed remainder, which takes the sign of B. Neither writes EX.
- R8: Opcodes 0a (AND), 0b (OR) and 0c (XOR) give the bitwise result of B and A and do not write EX.
- R9: Opcode 0d (logical right shift) gives result = B >> A, which is 0000 for A ≥ 16. EX is written with the low 16 bits of (B·2^16) >> A, which is 0000 for A ≥ 32.
- R10: Opcode 0e (arithmetic right shift) shifts the signed B right by A. For A ≥ 16 every bit of the result equals the sign bit of B. EX is written with the low 16 bits of the signed value (B·2^16) shifted arithmetically right by A.
- R11: Opcode 0f (left shift) gives result = (B << A) mod 2^16, which is 0000 for A ≥ 16. EX is written with bits 31..16 of the 32-bit value B << A.
- R12: Opcode 1a (add with EX) gives result = (B+A+EX) mod 2^16. EX is written with 0001 when the sum exceeds ffff and with 0000 otherwise.
- R13: Opcode 1b (subtract with EX) gives result = (B−A+EX) mod 2^16. EX is written with ffff when B−A+EX is negative and with 0000 otherwise.
- R14: Any other opcode gives result = B and ex_we = 0. For every opcode, whenever ex_we is 0, ex_out equals ex_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Basic operation code |
| opnd_b | input | 16 | Destination operand B |
| opnd_a | input | 16 | Source operand A, which is also the shift amount |
| ex_in | input | 16 | Current overflow word |
| result | output | 16 | Value to be written back to B |
| ex_out | output | 16 | New overflow word, equal to ex_in when not written |
| ex_we | output | 1 | Overflow word write enable |

## Verification
The hardest cases to reach are at the edges of signed arithmetic. One is dividing the most negative value by minus one. Another is the fraction of a signed quotient whose shifted dividend reaches −2^31. A third is an arithmetic shift by 32 or more, where EX must be filled entirely with the sign. Random operands almost never produce these. The stimulus therefore lists them as directed vectors, and it builds its random operands from a mix of full-range words, small shift amounts and the four values 0000, 0001, 8000 and ffff. This mix regularly produces zero divisors, carries out of ffff and shifts at 16 and beyond. The add-with-EX and subtract-with-EX cases also get a nonzero ex_in, so that the incoming overflow word changes whether the sum wraps or the difference goes negative.

// File: rtl/ovf_alu_pkg.sv
// Shared opcode encoding and unit classification for the overflow-word ALU.
// Assumes a 5-bit basic opcode; unlisted codes are treated as no operation.
package ovf_alu_pkg;
    typedef logic [4:0] opcode_t;

    localparam opcode_t OP_MOVE = 5'h01;
    localparam opcode_t OP_ADD  = 5'h02;
    localparam opcode_t OP_SUB  = 5'h03;
    localparam opcode_t OP_MULU = 5'h04;
    localparam opcode_t OP_MULS = 5'h05;
    localparam opcode_t OP_DIVU = 5'h06;
    localparam opcode_t OP_DIVS = 5'h07;
    localparam opcode_t OP_MODU = 5'h08;
    localparam opcode_t OP_MODS = 5'h09;
    localparam opcode_t OP_AND  = 5'h0a;
    localparam opcode_t OP_OR   = 5'h0b;
    localparam opcode_t OP_XOR  = 5'h0c;
    localparam opcode_t OP_SRL  = 5'h0d;
    localparam opcode_t OP_SRA  = 5'h0e;
    localparam opcode_t OP_SLL  = 5'h0f;
    localparam opcode_t OP_ADDC = 5'h1a;
    localparam opcode_t OP_SUBC = 5'h1b;

    typedef enum logic [2:0] {
        UNIT_NONE, UNIT_MOVE, UNIT_ARITH, UNIT_MULDIV, UNIT_LOGIC, UNIT_SHIFT
    } unit_e;

    // Which datapath unit produces the result for an opcode.
    function automatic unit_e unit_of(opcode_t op);
        case (op)
            OP_MOVE:                                   return UNIT_MOVE;
            OP_ADD, OP_SUB, OP_ADDC, OP_SUBC:          return UNIT_ARITH;
            OP_MULU, OP_MULS, OP_DIVU, OP_DIVS,
            OP_MODU, OP_MODS:                          return UNIT_MULDIV;
            OP_AND, OP_OR, OP_XOR:                     return UNIT_LOGIC;
            OP_SRL, OP_SRA, OP_SLL:                    return UNIT_SHIFT;
            default:                                   return UNIT_NONE;
        endcase
    endfunction

    // Whether an opcode updates the overflow word.
    function automatic logic writes_ex(opcode_t op);
        case (op)
            OP_ADD, OP_SUB, OP_ADDC, OP_SUBC,
            OP_MULU, OP_MULS, OP_DIVU, OP_DIVS,
            OP_SRL, OP_SRA, OP_SLL:                    return 1'b1;
            default:                                   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/ovf_alu_addsub.sv
// Add and subtract unit, with and without the incoming overflow word.
// Produces the wrapped result and the overflow/borrow marker for EX.
// Assumes the caller ignores ex_new for opcodes that are not add/subtract.
module ovf_alu_addsub
    import ovf_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  opcode_t        op,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   ex_in,
    output logic [W-1:0]   res,
    output logic [W-1:0]   ex_new
);
    localparam int XW = W + 2;
    localparam logic [W-1:0] EX_ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W:0]    add2;
    logic [W:0]    sub2;
    logic [XW-1:0] add3;
    logic [W:0]    sbc_pos;
    logic          sbc_neg;

    assign add2    = {1'b0, b} + {1'b0, a};
    assign sub2    = {1'b0, b} - {1'b0, a};
    assign add3    = {2'b00, b} + {2'b00, a} + {2'b00, ex_in};
    assign sbc_pos = {1'b0, b} + {1'b0, ex_in};
    assign sbc_neg = sbc_pos < {1'b0, a};

    // Select the sum or difference and its EX marker.
    always_comb begin
        case (op)
            OP_ADD: begin
                res    = add2[W-1:0];
                ex_new = add2[W] ? EX_ONE : '0;
            end
            OP_SUB: begin
                res    = sub2[W-1:0];
                ex_new = sub2[W] ? '1 : '0;
            end
            OP_ADDC: begin
                res    = add3[W-1:0];
                ex_new = (|add3[XW-1:W]) ? EX_ONE : '0;
            end
            OP_SUBC: begin
                res    = sbc_pos[W-1:0] - a;
                ex_new = sbc_neg ? '1 : '0;
            end
            default: begin
                res    = b;
                ex_new = ex_in;
            end
        endcase
    end
endmodule

// File: rtl/ovf_alu_muldiv.sv
// Multiply, divide and remainder unit, unsigned and signed.
// A zero divisor yields zero results; the divisor is forced to one internally
// so no undefined division is ever evaluated. Signed division is carried out
// at 2W+2 bits so that the most negative dividend cannot overflow.
module ovf_alu_muldiv
    import ovf_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  opcode_t        op,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   ex_in,
    output logic [W-1:0]   res,
    output logic [W-1:0]   ex_new
);
    localparam int PW = 2 * W;
    localparam int SW = 2 * W + 2;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic                 a_zero;
    logic [W-1:0]         a_safe;
    logic [PW-1:0]        prod_u;
    logic [PW-1:0]        prod_s;
    logic [W-1:0]         quo_u, frac_u, rem_u;
    logic signed [SW-1:0] sb, sa, sb_hi;
    logic [W-1:0]         quo_s, frac_s, rem_s;

    assign a_zero = (a == '0);
    assign a_safe = a_zero ? ONE : a;

    assign prod_u = {{W{1'b0}}, b} * {{W{1'b0}}, a};
    assign prod_s = $signed({{W{b[W-1]}}, b}) * $signed({{W{a[W-1]}}, a});

    assign quo_u  = b / a_safe;
    assign frac_u = W'({b, {W{1'b0}}} / {{W{1'b0}}, a_safe});
    assign rem_u  = b % a_safe;

    assign sb     = $signed({{(W+2){b[W-1]}}, b});
    assign sa     = $signed({{(W+2){a_safe[W-1]}}, a_safe});
    assign sb_hi  = sb <<< W;
    assign quo_s  = W'(sb / sa);
    assign frac_s = W'(sb_hi / sa);
    assign rem_s  = W'(sb % sa);

    // Select the product half, quotient or remainder and its EX value.
    always_comb begin
        res    = b;
        ex_new = ex_in;
        case (op)
            OP_MULU: begin res = prod_u[W-1:0]; ex_new = prod_u[PW-1:W]; end
            OP_MULS: begin res = prod_s[W-1:0]; ex_new = prod_s[PW-1:W]; end
            OP_DIVU: begin
                res    = a_zero ? '0 : quo_u;
                ex_new = a_zero ? '0 : frac_u;
            end
            OP_DIVS: begin
                res    = a_zero ? '0 : quo_s;
                ex_new = a_zero ? '0 : frac_s;
            end
            OP_MODU: res = a_zero ? '0 : rem_u;
            OP_MODS: res = a_zero ? '0 : rem_s;
            default: ;
        endcase
    end
endmodule

// File: rtl/ovf_alu_shift.sv
// Shift unit: logical right, arithmetic right and left, by the full
// W-bit amount in a. Each shift runs on a 2W-bit window so that the result
// half and the shifted-out half (for EX) come out of one shifter.
module ovf_alu_shift
    import ovf_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  opcode_t        op,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   ex_in,
    output logic [W-1:0]   res,
    output logic [W-1:0]   ex_new
);
    localparam int PW = 2 * W;

    logic [PW-1:0]        win_srl;
    logic signed [PW-1:0] win_sra;
    logic [PW-1:0]        win_sll;

    assign win_srl = {b, {W{1'b0}}} >> a;
    assign win_sra = $signed({b, {W{1'b0}}}) >>> a;
    assign win_sll = {{W{1'b0}}, b} << a;

    // Split the window into the result half and the spilled half.
    always_comb begin
        case (op)
            OP_SRL:  begin res = win_srl[PW-1:W]; ex_new = win_srl[W-1:0]; end
            OP_SRA:  begin res = win_sra[PW-1:W]; ex_new = win_sra[W-1:0]; end
            OP_SLL:  begin res = win_sll[W-1:0];  ex_new = win_sll[PW-1:W]; end
            default: begin res = b;               ex_new = ex_in;           end
        endcase
    end
endmodule

// File: rtl/ovf_alu.sv
// Top of the overflow-word ALU. Purely combinational: it selects one of the
// arithmetic, multiply/divide, logic or shift results by opcode and raises
// ex_we for the opcodes that update EX. When EX is not written, ex_out
// carries ex_in unchanged. Unknown opcodes pass B through.
module ovf_alu
    import ovf_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [4:0]   op_code,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] ex_in,
    output logic [W-1:0] result,
    output logic [W-1:0] ex_out,
    output logic         ex_we
);
    unit_e        unit;
    logic         we;
    logic [W-1:0] arith_res, arith_ex;
    logic [W-1:0] md_res, md_ex;
    logic [W-1:0] sh_res, sh_ex;
    logic [W-1:0] logic_res;

    assign unit = unit_of(op_code);
    assign we   = writes_ex(op_code);

    ovf_alu_addsub #(.W(W)) u_addsub (
        .op(op_code), .b(opnd_b), .a(opnd_a), .ex_in(ex_in),
        .res(arith_res), .ex_new(arith_ex)
    );

    ovf_alu_muldiv #(.W(W)) u_muldiv (
        .op(op_code), .b(opnd_b), .a(opnd_a), .ex_in(ex_in),
        .res(md_res), .ex_new(md_ex)
    );

    ovf_alu_shift #(.W(W)) u_shift (
        .op(op_code), .b(opnd_b), .a(opnd_a), .ex_in(ex_in),
        .res(sh_res), .ex_new(sh_ex)
    );

    // Bitwise operations.
    always_comb begin
        case (op_code)
            OP_AND:  logic_res = opnd_b & opnd_a;
            OP_OR:   logic_res = opnd_b | opnd_a;
            OP_XOR:  logic_res = opnd_b ^ opnd_a;
            default: logic_res = opnd_b;
        endcase
    end

    // Route the selected unit to the outputs and gate the EX update.
    always_comb begin
        result = opnd_b;
        ex_out = ex_in;
        case (unit)
            UNIT_MOVE:   result = opnd_a;
            UNIT_ARITH:  begin result = arith_res; if (we) ex_out = arith_ex; end
            UNIT_MULDIV: begin result = md_res;    if (we) ex_out = md_ex;    end
            UNIT_LOGIC:  result = logic_res;
            UNIT_SHIFT:  begin result = sh_res;    if (we) ex_out = sh_ex;    end
            default:     ;
        endcase
        ex_we = we;
    end
endmodule

// File: rtl/ovf_alu_chk.sv
// Property checker for the overflow-word ALU, bound to every instance.
// The block has no clock, so each check is an immediate assertion that is
// re-evaluated whenever a port changes.
module ovf_alu_chk
    import ovf_alu_pkg::*;
#(
    parameter int W = 16
) (
    input logic [4:0]   op_code,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] ex_in,
    input logic [W-1:0] result,
    input logic [W-1:0] ex_out,
    input logic         ex_we
);
    localparam int PW = 2 * W;

    logic [W:0]    sum_w;
    logic [W-1:0]  back_add;
    logic [PW-1:0] lo_prod, hi_prod;

    assign sum_w    = {1'b0, opnd_b} + {1'b0, opnd_a};
    assign back_add = result + opnd_a;
    assign lo_prod  = {{W{1'b0}}, result} * {{W{1'b0}}, opnd_a};
    assign hi_prod  = lo_prod + {{W{1'b0}}, opnd_a};

    // Port-level properties, checked whenever an input or output moves.
    always_comb begin
        AST_SET_COPY: assert (op_code != OP_MOVE || (result == opnd_a && !ex_we)); // R1
        AST_ADD_CARRY: assert (op_code != OP_ADD ||
            (ex_we && {ex_out[0], result} == sum_w && ex_out[W-1:1] == '0)); // R2
        AST_SUB_BORROW: assert (op_code != OP_SUB ||
            (back_add == opnd_b && ex_out == ((opnd_a > opnd_b) ? '1 : '0))); // R3
        AST_DIV_BOUND: assert (op_code != OP_DIVU || opnd_a == '0 ||
            (lo_prod <= {{W{1'b0}}, opnd_b} && hi_prod > {{W{1'b0}}, opnd_b})); // R5
        AST_ZERO_DIVISOR: assert (opnd_a != '0 ||
            !(op_code inside {OP_DIVU, OP_DIVS, OP_MODU, OP_MODS}) || result == '0); // R6
        AST_LOGIC_KEEPS_EX: assert (!(op_code inside {OP_AND, OP_OR, OP_XOR}) || !ex_we); // R8
        AST_SHL_FLUSH: assert (op_code != OP_SLL || opnd_a < W[W-1:0] || result == '0); // R11
        AST_EX_HOLD: assert (ex_we || ex_out == ex_in); // R14
    end
endmodule

bind ovf_alu ovf_alu_chk #(.W(W)) u_ovf_alu_chk (
    .op_code(op_code), .opnd_b(opnd_b), .opnd_a(opnd_a), .ex_in(ex_in),
    .result(result), .ex_out(ex_out), .ex_we(ex_we)
);

// File: tb/ovf_alu_test.sv
// Self-checking bench: stimulus is queued, applied on falling edges and
// compared on rising edges against a behavioural integer model.
module ovf_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_code = '0;
    logic [15:0] opnd_b = '0, opnd_a = '0, ex_in = '0;
    logic [15:0] result, ex_out;
    logic        ex_we;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit reported = 1'b0;

    logic [4:0]  q_op[$];
    logic [15:0] q_b[$], q_a[$], q_x[$];
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    ovf_alu uut (
        .op_code(op_code), .opnd_b(opnd_b), .opnd_a(opnd_a), .ex_in(ex_in),
        .result(result), .ex_out(ex_out), .ex_we(ex_we)
    );

    // Requirement tag for an applied vector.
    function automatic string req_of(logic [4:0] op, logic [15:0] a);
        case (op)
            5'h01: return "R1";
            5'h02: return "R2";
            5'h03: return "R3";
            5'h04, 5'h05: return "R4";
            5'h06, 5'h07: return (a == 0) ? "R6" : "R5";
            5'h08, 5'h09: return (a == 0) ? "R6" : "R7";
            5'h0a, 5'h0b, 5'h0c: return "R8";
            5'h0d: return "R9";
            5'h0e: return "R10";
            5'h0f: return "R11";
            5'h1a: return "R12";
            5'h1b: return "R13";
            default: return "R14";
        endcase
    endfunction

    // Behavioural reference computed with wide integers.
    task automatic model(input logic [4:0] op, input longint ub, input longint ua,
                         input longint ux, output longint r, output longint x,
                         output bit we);
        longint sb, sa, t;
        sb = (ub >= 32768) ? ub - 65536 : ub;
        sa = (ua >= 32768) ? ua - 65536 : ua;
        r = ub; x = ux; we = 1'b0;
        case (op)
            5'h01: r = ua;
            5'h02: begin t = ub + ua; r = t; x = (t > 65535) ? 1 : 0; we = 1; end
            5'h03: begin r = ub - ua; x = (ua > ub) ? 65535 : 0; we = 1; end
            5'h04: begin t = ub * ua; r = t; x = t >> 16; we = 1; end
            5'h05: begin t = sb * sa; r = t; x = t >>> 16; we = 1; end
            5'h06: begin
                we = 1;
                if (ua == 0) begin r = 0; x = 0; end
                else begin r = ub / ua; x = (ub * 65536) / ua; end
            end
            5'h07: begin
                we = 1;
                if (sa == 0) begin r = 0; x = 0; end
                else begin r = sb / sa; x = (sb * 65536) / sa; end
            end
            5'h08: r = (ua == 0) ? 0 : ub % ua;
            5'h09: r = (sa == 0) ? 0 : sb % sa;
            5'h0a: r = ub & ua;
            5'h0b: r = ub | ua;
            5'h0c: r = ub ^ ua;
            5'h0d: begin
                r = (ua >= 16) ? 0 : ub >> ua;
                x = (ua >= 32) ? 0 : (ub * 65536) >> ua; we = 1;
            end
            5'h0e: begin
                r = sb >>> ((ua >= 16) ? 16 : ua);
                x = (sb * 65536) >>> ((ua >= 32) ? 32 : ua); we = 1;
            end
            5'h0f: begin
                r = (ua >= 16) ? 0 : ub << ua;
                x = (ua >= 32) ? 0 : (ub << ua) >> 16; we = 1;
            end
            5'h1a: begin t = ub + ua + ux; r = t; x = (t > 65535) ? 1 : 0; we = 1; end
            5'h1b: begin t = ub - ua + ux; r = t; x = (t < 0) ? 65535 : 0; we = 1; end
            default: ;
        endcase
        r = r & 64'hffff;
        x = x & 64'hffff;
    endtask

    task automatic push(input logic [4:0] op, input logic [15:0] b, input logic [15:0] a,
                        input logic [15:0] x);
        q_op.push_back(op); q_b.push_back(b); q_a.push_back(a); q_x.push_back(x);
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 17);
        return v ^ (v << 5);
    endfunction

    function automatic logic [15:0] pick(input logic [31:0] s);
        logic [15:0] corner[4] = '{16'h0000, 16'h0001, 16'h8000, 16'hffff};
        case (s[31:30])
            2'd0: return s[15:0];
            2'd1: return {11'd0, s[4:0]} + {10'd0, s[5], 5'd0};
            2'd2: return corner[s[9:8]];
            default: return s[20:5];
        endcase
    endfunction

    task automatic compare(input string what, input string tag, input longint act,
                           input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s op=%h b=%h a=%h ex=%h actual=%h expected=%h",
                     tag, what, op_code, opnd_b, opnd_a, ex_in, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Compare every output against the model on each rising edge.
    always @(posedge clk) begin
        longint r, x;
        bit we;
        if (!done) begin
            model(op_code, longint'(opnd_b), longint'(opnd_a), longint'(ex_in), r, x, we);
            compare("result", req_of(op_code, opnd_a), longint'(result), r);
            compare("ex_we", req_of(op_code, opnd_a), longint'(ex_we), longint'(we));
            compare("ex_out", req_of(op_code, opnd_a), longint'(ex_out), x);
        end
    end

    // Stimulus: reset-state vector, directed corners, then mixed random vectors.
    initial begin
        // R2 carry out and plain sum
        push(5'h02, 16'hffff, 16'h0001, 16'h1234);
        push(5'h02, 16'h0001, 16'h0002, 16'hffff);
        // R3 borrow and equal operands
        push(5'h03, 16'h0001, 16'h0002, 16'h0000);
        push(5'h03, 16'h0005, 16'h0005, 16'h7777);
        // R4 unsigned and signed products
        push(5'h04, 16'hffff, 16'hffff, 16'h0000);
        push(5'h05, 16'hffff, 16'hffff, 16'h0000);
        push(5'h05, 16'h8000, 16'h0002, 16'h0000);
        // R5 fractions, truncation toward zero, most negative / -1
        push(5'h06, 16'h0001, 16'h0002, 16'h0000);
        push(5'h07, 16'hfff9, 16'h0002, 16'h0000);
        push(5'h07, 16'h8000, 16'hffff, 16'h5555);
        push(5'h07, 16'h8000, 16'h0001, 16'h5555);
        // R6 zero divisor on all four
        push(5'h06, 16'h0007, 16'h0000, 16'h4444);
        push(5'h07, 16'h8000, 16'h0000, 16'h4444);
        push(5'h08, 16'h0007, 16'h0000, 16'h4444);
        push(5'h09, 16'hfff9, 16'h0000, 16'h4444);
        // R7 remainder signs
        push(5'h08, 16'h0011, 16'h0005, 16'h9999);
        push(5'h09, 16'hfff9, 16'h0002, 16'h9999);
        push(5'h09, 16'h0007, 16'hfffe, 16'h9999);
        // R8 bitwise keep EX
        push(5'h0a, 16'hf0f0, 16'h3c3c, 16'habcd);
        push(5'h0b, 16'hf0f0, 16'h3c3c, 16'habcd);
        push(5'h0c, 16'hf0f0, 16'h3c3c, 16'habcd);
        // R9 logical right at 1, 16, 40
        push(5'h0d, 16'h8001, 16'h0001, 16'h0000);
        push(5'h0d, 16'h8001, 16'h0010, 16'h0000);
        push(5'h0d, 16'h8001, 16'h0028, 16'h0000);
        // R10 arithmetic right with sign fill, including 32 and beyond
        push(5'h0e, 16'h8000, 16'h0014, 16'h0000);
        push(5'h0e, 16'h8000, 16'h0020, 16'h0000);
        push(5'h0e, 16'h4000, 16'h0021, 16'h0000);
        // R11 left shift spill and flush
        push(5'h0f, 16'hffff, 16'h0004, 16'h0000);
        push(5'h0f, 16'h00ff, 16'h0018, 16'h0000);
        push(5'h0f, 16'hffff, 16'h0020, 16'h0000);
        // R12 carry-in causing wrap
        push(5'h1a, 16'hffff, 16'h0000, 16'h0001);
        push(5'h1a, 16'h0001, 16'h0001, 16'h0000);
        // R13 borrow rescued by EX and not rescued
        push(5'h1b, 16'h0000, 16'h0001, 16'h0000);
        push(5'h1b, 16'h0000, 16'h0001, 16'h0001);
        push(5'h1b, 16'hffff, 16'h0000, 16'hffff);
        // R1 move
        push(5'h01, 16'h1111, 16'hbeef, 16'h2222);
        // R14 undefined opcodes pass B and keep EX
        push(5'h00, 16'h1357, 16'h2468, 16'hcafe);
        push(5'h10, 16'h1357, 16'h2468, 16'hcafe);
        push(5'h1f, 16'h1357, 16'h2468, 16'hcafe);

        for (int n = 0; n < 3000; n++) begin
            logic [4:0] ops[18] = '{5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07,
                                    5'h08, 5'h09, 5'h0a, 5'h0b, 5'h0c, 5'h0d, 5'h0e,
                                    5'h0f, 5'h1a, 5'h1b, 5'h15};
            logic [15:0] vb, va, vx;
            rng = step(rng); vb = pick(rng);
            rng = step(rng); va = pick(rng);
            rng = step(rng); vx = pick(rng);
            push(ops[n % 18], vb, va, vx);
        end

        // Reset state: zero inputs are checked while reset is held.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        while (q_op.size() > 0) begin
            @(negedge clk);
            op_code = q_op.pop_front();
            opnd_b  = q_b.pop_front();
            opnd_a  = q_a.pop_front();
            ex_in   = q_x.pop_front();
        end
        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!reported) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1'b1;
            finish_run();
        end
    end
endmodule